// File: doc/BRIEF.md
# GPIO Direction and Masked Output Register Block

This block holds the direction and output state of 32 general-purpose pins behind a simple 32-bit register bus. Software never has to read a register, modify it and write it back. Direction bits change only through two strobe registers: one turns selected pins into outputs and the other turns selected pins into inputs. Output values are written one half-word at a time. Each write carries a per-pin mask that decides which pins take the new value.

The input levels of the pins pass through a two-flop synchronizer and a capture register, and software reads the captured value. The pad drivers use `pin_oe` as the enable and `pin_out` as the value. The output latch keeps its value whether or not the pin is driven. Software can therefore load a value first and turn on the driver afterwards.

Every bus access completes in one cycle. A write takes effect at the clock edge that ends its cycle. Read data is combinational and is valid in the same cycle as `bus_rd`.

Top module: `gpio_dir_out`

## Requirements
- R1: After reset, `pin_oe` and `pin_out` are all zero, and reads of offsets 0x04 and 0x10 return zero while the pins are low.
- R2: A write to offset 0x00 makes every pin whose data bit is 1 an output (`pin_oe` bit = 1). All other direction bits keep their value.
- R3: A write to offset 0x04 makes every pin whose data bit is 1 an input. A read of offset 0x04 returns the 32 direction bits, where bit n = 1 means pin n is an output.
- R4: A write to offset 0x08 updates pins 0..15. Data bits 31:16 are the mask and bits 15:0 are the values. Pin n takes value bit n only when mask bit n+16 is 1. A zero mask changes nothing.
- R5: A write to offset 0x0C updates pins 16..31 with the same layout. Pin 16+k takes value bit k when mask bit 16+k is 1.
- R6: `pin_out` always shows the output latch, including for pins in input mode. Direction writes never change the latch.
- R7: A read of offset 0x10 returns the pin input levels. A change on `pin_in` shows up in that read three clock edges later: two synchronizer flops and then the capture register.
- R8: Reads of any offset other than 0x04 and 0x10 return zero, including the write-only offsets 0x00, 0x08 and 0x0C. Writes to any offset other than 0x00, 0x04, 0x08 and 0x0C change no state.
- R9: When successive writes to the set and clear direction offsets name the same pin, the later write decides that pin's direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while `bus_rd` is high |
| pin_in | input | 32 | Asynchronous pin input levels |
| pin_out | output | 32 | Output latch value to the pads |
| pin_oe | output | 32 | Per-pin output enable |

## Verification
The half-word output writes are tried with full, partial, alternating-byte and empty masks. These patterns tell a correctly masked merge apart from a plain overwrite, from a mask taken from the wrong half of the word, and from a write that reaches the wrong half of the pins. The direction strobes are given overlapping and disjoint bit sets, and the same bit is set and then cleared in both orders. This separates OR/AND-NOT updates from a direct load and shows which write wins. The input path is sampled on the second and third cycle after a change, which pins down the synchronizer depth. Unmapped and write-only offsets are both written and read to confirm that they are inert.

// File: rtl/gpio_dir_out.sv
module gpio_dir_out #(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [31:0]       pin_in,
  output logic [31:0]       pin_out,
  output logic [31:0]       pin_oe
);
  localparam logic [ADDR_W-1:0] OFF_SET = ADDR_W'('h00);
  localparam logic [ADDR_W-1:0] OFF_CLR = ADDR_W'('h04);
  localparam logic [ADDR_W-1:0] OFF_LO  = ADDR_W'('h08);
  localparam logic [ADDR_W-1:0] OFF_HI  = ADDR_W'('h0c);
  localparam logic [ADDR_W-1:0] OFF_IN  = ADDR_W'('h10);

  logic [31:0] dir_q, sync1_q, sync2_q, in_q;
  logic [15:0] out_lo_q, out_hi_q;

  wire         wr_set = bus_wr && bus_addr == OFF_SET;
  wire         wr_clr = bus_wr && bus_addr == OFF_CLR;
  wire         wr_lo  = bus_wr && bus_addr == OFF_LO;
  wire         wr_hi  = bus_wr && bus_addr == OFF_HI;
  wire  [15:0] w_mask = bus_wdata[31:16];
  wire  [15:0] w_val  = bus_wdata[15:0];

  always_ff @(posedge clk) begin
    if (!rst_n)      dir_q <= '0;
    else if (wr_set) dir_q <= dir_q | bus_wdata;
    else if (wr_clr) dir_q <= dir_q & ~bus_wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     out_lo_q <= '0;
    else if (wr_lo) out_lo_q <= (out_lo_q & ~w_mask) | (w_val & w_mask);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     out_hi_q <= '0;
    else if (wr_hi) out_hi_q <= (out_hi_q & ~w_mask) | (w_val & w_mask);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync1_q <= '0;
      sync2_q <= '0;
      in_q    <= '0;
    end else begin
      sync1_q <= pin_in;
      sync2_q <= sync1_q;
      in_q    <= sync2_q;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      if (bus_addr == OFF_CLR)     bus_rdata = dir_q;
      else if (bus_addr == OFF_IN) bus_rdata = in_q;
    end
  end

  assign pin_out = {out_hi_q, out_lo_q};
  assign pin_oe  = dir_q;
endmodule

module gpio_dir_out_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic [31:0]       bus_rdata,
  input logic [31:0]       pin_in,
  input logic [31:0]       pin_out,
  input logic [31:0]       pin_oe
);
  logic [2:0] age;
  always_ff @(posedge clk) begin
    if (!rst_n)         age <= '0;
    else if (age != 3'd4) age <= age + 3'd1;
  end

  wire hit_set = bus_wr && bus_addr == ADDR_W'('h00);
  wire hit_clr = bus_wr && bus_addr == ADDR_W'('h04);
  wire hit_lo  = bus_wr && bus_addr == ADDR_W'('h08);
  wire hit_hi  = bus_wr && bus_addr == ADDR_W'('h0c);

  p_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    hit_set |=> pin_oe == ($past(pin_oe) | $past(bus_wdata)));

  p_clr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    hit_clr |=> pin_oe == ($past(pin_oe) & ~$past(bus_wdata)));

  p_dir_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(hit_set || hit_clr) |=> $stable(pin_oe));

  p_lo_mask_r4: assert property (@(posedge clk) disable iff (!rst_n)
    hit_lo |=> (pin_out[15:0] == (($past(pin_out[15:0]) & ~$past(bus_wdata[31:16])) |
                                 ($past(bus_wdata[15:0]) & $past(bus_wdata[31:16]))))
               && pin_out[31:16] == $past(pin_out[31:16]));

  p_hi_mask_r5: assert property (@(posedge clk) disable iff (!rst_n)
    hit_hi |=> (pin_out[31:16] == (($past(pin_out[31:16]) & ~$past(bus_wdata[31:16])) |
                                  ($past(bus_wdata[15:0]) & $past(bus_wdata[31:16]))))
               && pin_out[15:0] == $past(pin_out[15:0]));

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(hit_lo || hit_hi) |=> $stable(pin_out));

  p_in_lat_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == ADDR_W'('h10) && age >= 3'd3) |-> bus_rdata == $past(pin_in, 3));

  p_dir_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == ADDR_W'('h04)) |-> bus_rdata == pin_oe);

  p_unmapped_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_rd || (bus_addr != ADDR_W'('h04) && bus_addr != ADDR_W'('h10))) |-> bus_rdata == '0);
endmodule

bind gpio_dir_out gpio_dir_out_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
);

// File: tb/sim_gpio_dir_out.sv
`timescale 1ns/1ps
module sim_gpio_dir_out;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        bus_wr = 0, bus_rd = 0, probe = 0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, pin_in = '0;
  logic [31:0] bus_rdata, pin_out, pin_oe;

  typedef struct {
    int          kind;
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t q[$];
  int    checks = 0, fails = 0;
  bit    done = 0;

  always #2 clk = ~clk;

  gpio_dir_out #(.ADDR_W(8)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  function automatic void compare(item_t it);
    logic [31:0] act;
    case (it.kind)
      0:       act = bus_rdata;
      1:       act = pin_oe;
      default: act = pin_out;
    endcase
    checks++;
    if (act !== it.exp) begin
      fails++;
      $display("FAIL %s kind=%0d actual=%08h expected=%08h", it.tag, it.kind, act, it.exp);
    end
  endfunction

  always @(negedge clk) begin
    #1;
    if (bus_rd && q.size() > 0) compare(q.pop_front());
    if (probe) begin
      if (q.size() > 0) compare(q.pop_front());
      if (q.size() > 0) compare(q.pop_front());
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag);
    item_t it;
    it.kind = 0; it.exp = e; it.tag = tag;
    q.push_back(it);
    bus_rd = 1; bus_addr = a;
    @(negedge clk);
    bus_rd = 0;
  endtask

  task automatic pins(input logic [31:0] oe, input logic [31:0] ov, input string tag);
    item_t a, b;
    a.kind = 1; a.exp = oe; a.tag = tag;
    b.kind = 2; b.exp = ov; b.tag = tag;
    q.push_back(a); q.push_back(b);
    probe = 1;
    @(negedge clk);
    probe = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    pins(32'h0, 32'h0, "R1 reset");
    rd(8'h04, 32'h0, "R1 dir read");
    rd(8'h10, 32'h0, "R1 input read");

    wr(8'h08, {16'h00FF, 16'hA5C3});
    pins(32'h0, 32'h0000_00C3, "R6 latch loads while input");
    wr(8'h08, {16'hFF00, 16'h5A3C});
    pins(32'h0, 32'h0000_5AC3, "R4 upper byte mask");
    wr(8'h08, {16'h0000, 16'hFFFF});
    pins(32'h0, 32'h0000_5AC3, "R4 zero mask");
    wr(8'h0c, {16'hFFFF, 16'h1234});
    pins(32'h0, 32'h1234_5AC3, "R5 full mask");
    wr(8'h0c, {16'h000F, 16'hFFF0});
    pins(32'h0, 32'h1230_5AC3, "R5 nibble mask");

    wr(8'h00, 32'h0000_00F0);
    pins(32'h0000_00F0, 32'h1230_5AC3, "R2 set");
    wr(8'h00, 32'h0F00_0001);
    pins(32'h0F00_00F1, 32'h1230_5AC3, "R2 set accumulate R6");
    wr(8'h04, 32'h0000_0030);
    pins(32'h0F00_00C1, 32'h1230_5AC3, "R3 clear");
    rd(8'h04, 32'h0F00_00C1, "R3 dir read");

    wr(8'h14, 32'hFFFF_FFFF);
    wr(8'h02, 32'hFFFF_FFFF);
    wr(8'h10, 32'hFFFF_FFFF);
    pins(32'h0F00_00C1, 32'h1230_5AC3, "R8 unmapped writes");
    rd(8'h00, 32'h0, "R8 read set offset");
    rd(8'h08, 32'h0, "R8 read low offset");
    rd(8'h0c, 32'h0, "R8 read high offset");
    rd(8'h20, 32'h0, "R8 read unmapped");

    wr(8'h00, 32'h8000_0000);
    wr(8'h04, 32'h8000_0000);
    pins(32'h0F00_00C1, 32'h1230_5AC3, "R9 clear last");
    wr(8'h04, 32'h0000_0002);
    wr(8'h00, 32'h0000_0002);
    pins(32'h0F00_00C3, 32'h1230_5AC3, "R9 set last");

    pin_in = 32'hDEAD_BEEF;
    @(negedge clk);
    @(negedge clk);
    rd(8'h10, 32'h0, "R7 two edges old");
    rd(8'h10, 32'hDEAD_BEEF, "R7 third edge new");
    pin_in = 32'h0F0F_0000;
    repeat (2) @(negedge clk);
    rd(8'h10, 32'hDEAD_BEEF, "R7 second pattern old");
    rd(8'h10, 32'h0F0F_0000, "R7 second pattern new");

    repeat (2) @(negedge clk);
    if (q.size() != 0) begin
      fails++;
      $display("FAIL scoreboard leftover=%0d expected=0", q.size());
    end
    done = 1;
  end

  initial begin
    for (int i = 0; i < 20000 && !done; i++) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule